// File: doc/BRIEF.md
# Global-History Two-Level Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps a shift register of the outcomes of the most recently resolved branches. It also keeps a pattern table of 2-bit saturating counters. The table index is formed by placing the history bits above a group of low-order word-address bits of the branch PC. The upper bit of the selected counter is the prediction. Two branches that reach the same code point through different recent paths therefore consult different counters.

Fetch presents a PC on the lookup port. In the same cycle the block returns the predicted direction and the history value it used. Fetch carries that history snapshot along with the branch. When the branch resolves, the pipeline presents the PC, the real outcome and the carried snapshot on the update port. The block then steps the counter that this snapshot and PC select, and shifts the outcome into the global history. The table has no tags, so branches that share index bits share a counter. If the history width is set to zero, the block becomes a plain PC-indexed counter table.

Top module: `gp_predictor`

## Requirements
- R1: After reset every counter holds weakly not-taken (binary 01), so every lookup predicts not-taken, and the global history reads all zeros.
- R2: `pred_taken` is bit 1 of the counter at index {history, pc[PC_LSB +: IDX_W-HIST_W]}, where history sits in the upper bits. It is valid in the same cycle as `lk_pc`.
- R3: A taken update adds one to the selected counter, and the counter saturates at 3 (binary 11).
- R4: A not-taken update subtracts one from the selected counter, and the counter saturates at 0 (binary 00).
- R5: Starting from a strong state, a single opposite outcome leaves the prediction unchanged. A second consecutive opposite outcome flips it.
- R6: An update selects its counter from `upd_hist`, the snapshot taken at prediction time, and not from the current history. Only that one counter changes.
- R7: When `upd_valid` is high, the history becomes {history[HIST_W-2:0], upd_taken}, so the newest outcome sits in bit 0. When `upd_valid` is low, the history holds.
- R8: `pred_hist` always shows the current global history, ready to be captured as the snapshot.
- R9: PC bits outside the index field do not affect selection. Two PCs that differ only above the field share one counter.
- R10: With HIST_W = 0, selection uses the PC field alone, and `pred_hist` is a single bit tied to 0.
- R11: The same PC under two different histories uses two independent counters.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_hist | output | max(HIST_W,1) | Current global history, to be carried as the snapshot |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Actual outcome (1 = taken) |
| upd_hist | input | max(HIST_W,1) | History snapshot captured when the branch was predicted |

## Verification
A prediction depends only on `lk_pc` and registered state, so it is due in the cycle the PC is applied. The bench samples it 1 ns after the PC changes, while the clock is still low. An update is captured on the rising edge during which `upd_valid` is high. Its effect on the counter and on the history is visible after that edge. The bench therefore drives each update on a falling edge, drops it on the next falling edge, and only then looks up. Because every update also moves the history, the bench steers the history back to a known value with updates to a scratch PC before it reads a counter under a chosen history.

// File: rtl/gp_pkg.sv
package gp_pkg;

  typedef logic [1:0] ctr_t;

  localparam ctr_t CTR_SNT = 2'b00;
  localparam ctr_t CTR_WNT = 2'b01;
  localparam ctr_t CTR_WT  = 2'b10;
  localparam ctr_t CTR_ST  = 2'b11;

  // saturating step of a direction counter
  function automatic ctr_t ctr_step(input ctr_t c, input logic taken);
    ctr_t r;
    if (taken) r = (c == CTR_ST)  ? c : ctr_t'(c + 2'd1);
    else       r = (c == CTR_SNT) ? c : ctr_t'(c - 2'd1);
    return r;
  endfunction

endpackage

// File: rtl/gp_history.sv
module gp_history #(
  parameter  int HIST_W = 2,
  localparam int HP_W   = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            shift_in,
  output logic [HP_W-1:0] hist_q
);

  generate
    if (HIST_W == 0) begin : g_none
      logic unused_hist_in;
      assign unused_hist_in = ^{clk, rst_n, shift_en, shift_in};
      assign hist_q = '0;
    end else begin : g_shift
      logic [HIST_W-1:0] hist_r;
      logic [HIST_W-1:0] hist_d;

      always_comb begin
        hist_d = hist_r;
        if (shift_en) hist_d = HIST_W'({hist_r, shift_in});
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        hist_r <= '0;
        else if (shift_en) hist_r <= hist_d;
      end

      assign hist_q = hist_r;

      // R7: newest outcome lands in bit 0
      assert_shift_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> hist_r[0] == $past(shift_in));

      // R7: no resolved branch, no history movement
      assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(hist_r));
    end
  endgenerate

endmodule

// File: rtl/gp_index.sv
module gp_index #(
  parameter  int HIST_W = 2,
  parameter  int PC_W   = 32,
  parameter  int PC_LSB = 2,
  parameter  int IDX_W  = 10,
  localparam int HP_W   = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [HP_W-1:0]  hist,
  output logic [IDX_W-1:0] idx
);

  localparam int PC_BITS = IDX_W - HIST_W;
  localparam logic [PC_W-1:0] FIELD_MASK =
    {{(PC_W-PC_BITS){1'b0}}, {PC_BITS{1'b1}}} << PC_LSB;

  generate
    if (HIST_W == 0) begin : g_pc_only
      logic unused_idx_in;
      assign unused_idx_in = ^{pc & ~FIELD_MASK, hist};
      assign idx = pc[PC_LSB +: IDX_W];
    end else begin : g_concat
      logic unused_idx_in;
      assign unused_idx_in = ^(pc & ~FIELD_MASK);
      assign idx = {hist, pc[PC_LSB +: PC_BITS]};
    end
  endgenerate

endmodule

// File: rtl/gp_pattern_table.sv
module gp_pattern_table
  import gp_pkg::*;
#(
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output ctr_t             rd_ctr,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             wr_taken
);

  localparam int DEPTH = 1 << IDX_W;

  ctr_t ctr_q [DEPTH];
  ctr_t wr_old;
  ctr_t wr_new;

  always_comb begin
    wr_old = ctr_q[wr_idx];
    wr_new = ctr_step(wr_old, wr_taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) ctr_q[i] <= CTR_WNT;
    end else if (wr_en) begin
      ctr_q[wr_idx] <= wr_new;
    end
  end

  assign rd_ctr = ctr_q[rd_idx];

  // R3: taken moves the counter up by one below the top
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old != CTR_ST)
      |=> ctr_q[$past(wr_idx)] == ctr_t'($past(wr_old) + 2'd1));

  // R3: taken at the top stays at the top
  assert_sat_hi_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && wr_old == CTR_ST) |=> ctr_q[$past(wr_idx)] == CTR_ST);

  // R4: not-taken moves the counter down by one above the bottom
  assert_dec_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old != CTR_SNT)
      |=> ctr_q[$past(wr_idx)] == ctr_t'($past(wr_old) - 2'd1));

  // R4: not-taken at the bottom stays at the bottom
  assert_sat_lo_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && wr_old == CTR_SNT) |=> ctr_q[$past(wr_idx)] == CTR_SNT);

endmodule

// File: rtl/gp_predictor.sv
module gp_predictor
  import gp_pkg::*;
#(
  parameter  int HIST_W = 2,
  parameter  int IDX_W  = 10,
  parameter  int PC_W   = 32,
  parameter  int PC_LSB = 2,
  localparam int HP_W   = (HIST_W > 0) ? HIST_W : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] lk_pc,
  output logic            pred_taken,
  output logic [HP_W-1:0] pred_hist,
  input  logic            upd_valid,
  input  logic [PC_W-1:0] upd_pc,
  input  logic            upd_taken,
  input  logic [HP_W-1:0] upd_hist
);

  logic [HP_W-1:0]  hist_q;
  logic [IDX_W-1:0] lk_idx;
  logic [IDX_W-1:0] up_idx;
  ctr_t             lk_ctr;
  logic             unused_ctr_lsb;

  gp_history #(.HIST_W(HIST_W)) u_hist (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (upd_valid),
    .shift_in (upd_taken),
    .hist_q   (hist_q)
  );

  gp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_lk_idx (
    .pc   (lk_pc),
    .hist (hist_q),
    .idx  (lk_idx)
  );

  gp_index #(.HIST_W(HIST_W), .PC_W(PC_W), .PC_LSB(PC_LSB), .IDX_W(IDX_W)) u_up_idx (
    .pc   (upd_pc),
    .hist (upd_hist),
    .idx  (up_idx)
  );

  gp_pattern_table #(.IDX_W(IDX_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lk_idx),
    .rd_ctr   (lk_ctr),
    .wr_en    (upd_valid),
    .wr_idx   (up_idx),
    .wr_taken (upd_taken)
  );

  assign pred_taken     = lk_ctr[1];
  assign unused_ctr_lsb = lk_ctr[0];
  assign pred_hist      = hist_q;

endmodule

// File: tb/gp_predictor_tb.sv
`timescale 1ns/1ps
module gp_predictor_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        upd_valid = 1'b0;
  logic        upd_valid2 = 1'b0;
  logic [31:0] upd_pc = '0;
  logic        upd_taken = 1'b0;
  logic [1:0]  upd_hist = '0;
  logic        pred_taken, pred_taken2;
  logic [1:0]  pred_hist;
  logic        pred_hist2;

  int checks = 0;
  int errors = 0;

  logic [1:0] m_ctr [1024];
  logic [1:0] m_hist;
  localparam logic [31:0] SCR = 32'h0000_03FC;

  always #2 clk = ~clk;

  gp_predictor #(.HIST_W(2), .IDX_W(10), .PC_W(32), .PC_LSB(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken),
    .pred_hist(pred_hist), .upd_valid(upd_valid), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(upd_hist)
  );

  gp_predictor #(.HIST_W(0), .IDX_W(10), .PC_W(32), .PC_LSB(2)) u_dut_pc (
    .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .pred_taken(pred_taken2),
    .pred_hist(pred_hist2), .upd_valid(upd_valid2), .upd_pc(upd_pc),
    .upd_taken(upd_taken), .upd_hist(1'b0)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] step(input logic [1:0] c, input logic t);
    if (t) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  task automatic upd(input logic [31:0] pc, input logic t, input logic [1:0] h);
    logic [9:0] ix;
    @(negedge clk);
    upd_pc = pc; upd_taken = t; upd_hist = h; upd_valid = 1'b1;
    @(negedge clk);
    upd_valid = 1'b0;
    ix = {h, pc[9:2]};
    m_ctr[ix] = step(m_ctr[ix], t);
    m_hist = {m_hist[0], t};
  endtask

  task automatic set_hist(input logic [1:0] h);
    upd(SCR, h[1], m_hist);
    upd(SCR, h[0], m_hist);
  endtask

  task automatic look(input logic [31:0] pc, input string tag, input logic exp);
    lk_pc = pc;
    #1;
    check(tag, pred_taken, exp);
    check({tag, " model"}, pred_taken, m_ctr[{m_hist, pc[9:2]}][1]);
    check("R8 pred_hist", pred_hist, m_hist);
  endtask

  task automatic t_reset();
    lk_pc = 32'h100; #1; check("R1 pc100", pred_taken, 0);
    lk_pc = 32'hABC; #1; check("R1 pcABC", pred_taken, 0);
    check("R1 hist zero", pred_hist, 2'b00);
    check("R10 reset pc-only", pred_taken2, 0);
  endtask

  task automatic t_train_sat();
    upd(32'h40, 1, 2'b00); upd(32'h40, 1, 2'b00);
    look(32'h40, "R11 other history untouched", 0);
    set_hist(2'b00);
    look(32'h40, "R2 trained taken", 1);
    upd(32'h40, 1, 2'b00); upd(32'h40, 1, 2'b00); upd(32'h40, 1, 2'b00);
    upd(32'h40, 0, 2'b00);
    set_hist(2'b00);
    look(32'h40, "R3 R5 one miss from strong keeps taken", 1);
    upd(32'h40, 0, 2'b00);
    set_hist(2'b00);
    look(32'h40, "R5 second miss flips", 0);
  endtask

  task automatic t_down_sat();
    upd(32'h40, 0, 2'b00); upd(32'h40, 0, 2'b00); upd(32'h40, 0, 2'b00);
    upd(32'h40, 1, 2'b00);
    set_hist(2'b00);
    look(32'h40, "R4 floor then one taken", 0);
    upd(32'h40, 1, 2'b00);
    set_hist(2'b00);
    look(32'h40, "R4 floor then two taken", 1);
  endtask

  task automatic t_captured();
    set_hist(2'b00);
    upd(32'h80, 1, 2'b10); upd(32'h80, 1, 2'b10);
    set_hist(2'b10);
    look(32'h80, "R6 snapshot counter trained", 1);
    set_hist(2'b00);
    look(32'h80, "R6 current-history counter untouched", 0);
  endtask

  task automatic t_shift();
    set_hist(2'b00);
    upd(SCR, 1, m_hist);
    check("R7 taken into bit0", pred_hist, 2'b01);
    upd(SCR, 0, m_hist);
    check("R7 shifted up", pred_hist, 2'b10);
    @(negedge clk);
    upd_taken = 1'b1; upd_pc = 32'h40; upd_hist = 2'b10;
    repeat (3) @(negedge clk);
    check("R7 hold without valid", pred_hist, 2'b10);
    look(32'h40, "R7 idle update ignored", m_ctr[{2'b10, 8'h10}][1]);
  endtask

  task automatic t_alias();
    set_hist(2'b00);
    upd(32'hC0, 1, 2'b00); upd(32'hC0, 1, 2'b00);
    set_hist(2'b00);
    look(32'h4C0, "R9 upper bits alias", 1);
    look(32'hC1, "R9 low byte bits ignored", 1);
  endtask

  task automatic t_pc_only();
    @(negedge clk);
    upd_pc = 32'h100; upd_taken = 1'b1; upd_valid2 = 1'b1;
    repeat (2) @(negedge clk);
    upd_valid2 = 1'b0;
    lk_pc = 32'h100; #1;
    check("R10 pc-only trained", pred_taken2, 1);
    check("R10 pc-only hist tied", pred_hist2, 0);
    lk_pc = 32'h104; #1;
    check("R10 neighbour untouched", pred_taken2, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) m_ctr[i] = 2'b01;
    m_hist = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_train_sat();
    t_down_sat();
    t_captured();
    t_shift();
    t_alias();
    t_pc_only();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule